// File: doc/BRIEF.md
# Converter Serial Result Reader

This block is the host side of a three-wire link to a delta-sigma converter that delivers a 24-bit word: four status bits followed by a 20-bit result, most significant bit first. A `start` pulse lowers chip select. The reader then watches the data line, which carries a live conversion-busy flag. While that flag reads high, the serial clock stays low and polling continues. Once the flag reads low, the reader produces the serial clock from the system clock. The high and low phase lengths are set by parameters. It samples one bit on every rising edge and releases chip select after the final falling edge.

When the word is complete, the reader presents the 20-bit result field, the sign flag, the over-range flag and a framing-error flag, and pulses `rd_valid` for one cycle. A `wide` input selects a 32-clock frame for systems built around the longer word length. In that frame the eight trailing bits must all read one. A programmable timeout ends a poll that never sees the busy flag clear. When it expires, `tmo_err` is set and chip select is released.

Top module: `adc_word_reader`

## Requirements
- R1: After reset `cs_n` is 1, `sclk` is 0, `rd_valid` is 0 and both `frame_err` and `tmo_err` are 0.
- R2: A `start` pulse in idle drives `cs_n` to 0. While the data line reads 1 (busy), `sclk` stays at 0 and `cs_n` stays at 0.
- R3: If the data line still reads 1 after `TMO_CYC` cycles of polling, `tmo_err` goes to 1 exactly `TMO_CYC` cycles after the start edge and `cs_n` returns to 1. No `rd_valid` pulse occurs. The next accepted `start` clears `tmo_err`.
- R4: Each `sclk` high phase lasts `HI_CYC` system cycles and each low phase before a rising edge lasts at least `LO_CYC` cycles. A frame has exactly 24 rising edges when `wide`=0 and exactly 32 when `wide`=1.
- R5: When the data line already reads 0, `rd_valid` is a one-cycle pulse that comes N·(`HI_CYC`+`LO_CYC`) cycles after the start edge, where N is 24 or 32. `cs_n` is 1 in that cycle.
- R6: The bits sampled on rising edges form the word w[23:0], with w[23] first. `result_mag` = w[19:0], `res_sign` = w[21] (1 = positive input) and `res_ovr` = w[20] (1 = input outside the nominal range).
- R7: `frame_err` is 1 with `rd_valid` when w[22] (always-zero bit) reads 1. Otherwise it is 0. `frame_err` changes only in a `rd_valid` cycle.
- R8: With `wide`=1, the 8 bits after w[0] are sampled as padding. `frame_err` is also 1 if any of them reads 0.
- R9: A `start` pulse while a read is in progress has no effect: the frame timing and the single `rd_valid` pulse are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a read (accepted only when idle) |
| wide | input | 1 | 1 selects the 32-clock frame, latched at start |
| sdi | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock to the converter |
| rd_valid | output | 1 | One-cycle strobe: new result on the outputs |
| result_mag | output | 20 | 20-bit result field |
| res_sign | output | 1 | Sign flag, 1 = positive |
| res_ovr | output | 1 | Over-range flag |
| frame_err | output | 1 | Always-zero bit or padding check failed |
| tmo_err | output | 1 | Busy flag never cleared within the timeout |

## Verification
When the busy flag is already clear, `rd_valid` is due N·(HI_CYC+LO_CYC) cycles after the start edge. The bench counts falling-edge samples from that edge and compares the count exactly. `tmo_err` is due TMO_CYC cycles after the start edge and is checked the same way. The result fields are read in the strobe cycle itself. The high-phase length and the number of rising edges are tallied from `sclk` samples taken on every falling system-clock edge. The no-effect checks for a repeated start and for the busy wait rely on those same counts staying unchanged.

// File: rtl/adc_word_reader.sv
module adc_word_reader #(
  parameter int HI_CYC  = 2,
  parameter int LO_CYC  = 3,
  parameter int TMO_CYC = 200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        wide,
  input  logic        sdi,
  output logic        cs_n,
  output logic        sclk,
  output logic        rd_valid,
  output logic [19:0] result_mag,
  output logic        res_sign,
  output logic        res_ovr,
  output logic        frame_err,
  output logic        tmo_err
);
  localparam int PMAX = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
  localparam int PW   = $clog2(PMAX + 1);
  localparam int TW   = $clog2(TMO_CYC + 1);

  typedef enum logic [1:0] {S_IDLE, S_POLL, S_HIGH, S_LOW} st_t;

  st_t           st;
  logic [PW-1:0] ph;
  logic [TW-1:0] tmo;
  logic [5:0]    nb;
  logic [31:0]   sh;
  logic          wide_q;

  wire        hi_done = (ph == PW'(HI_CYC - 1));
  wire        lo_done = (ph == PW'(LO_CYC - 1));
  wire [5:0]  nlast   = wide_q ? 6'd32 : 6'd24;
  wire [23:0] word    = wide_q ? sh[31:8] : sh[23:0];
  wire        pad_bad = wide_q & ~(&sh[7:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; tmo <= '0; nb <= '0; sh <= '0; wide_q <= 1'b0;
      cs_n <= 1'b1; sclk <= 1'b0; rd_valid <= 1'b0;
      result_mag <= '0; res_sign <= 1'b0; res_ovr <= 1'b0;
      frame_err <= 1'b0; tmo_err <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st <= S_POLL; cs_n <= 1'b0; ph <= '0; tmo <= '0; nb <= '0;
          wide_q <= wide; tmo_err <= 1'b0;
        end
        S_POLL: begin
          if (lo_done && !sdi) begin
            sclk <= 1'b1; sh <= {sh[30:0], sdi}; nb <= 6'd1;
            ph <= '0; st <= S_HIGH;
          end else if (tmo == TW'(TMO_CYC - 1)) begin
            tmo_err <= 1'b1; cs_n <= 1'b1; st <= S_IDLE;
          end else begin
            tmo <= tmo + 1'b1;
            if (!lo_done) ph <= ph + 1'b1;
          end
        end
        S_HIGH: begin
          if (hi_done) begin
            sclk <= 1'b0; ph <= '0;
            if (nb == nlast) begin
              cs_n <= 1'b1; rd_valid <= 1'b1; st <= S_IDLE;
              result_mag <= word[19:0]; res_sign <= word[21]; res_ovr <= word[20];
              frame_err <= word[23] | word[22] | pad_bad;
            end else st <= S_LOW;
          end else ph <= ph + 1'b1;
        end
        S_LOW: begin
          if (lo_done) begin
            sclk <= 1'b1; sh <= {sh[30:0], sdi}; nb <= nb + 1'b1;
            ph <= '0; st <= S_HIGH;
          end else ph <= ph + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_word_reader_chk.sv
module adc_word_reader_chk #(
  parameter int HI_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sclk,
  input logic rd_valid,
  input logic frame_err,
  input logic tmo_err
);
  logic [7:0] hc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hc <= '0;
    else        hc <= sclk ? hc + 8'd1 : 8'd0;
  end

  p_sclk_idle_r2: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sclk);
  p_tmo_release_r3: assert property (@(posedge clk) disable iff (!rst_n) $rose(tmo_err) |-> cs_n && !rd_valid);
  p_hi_len_r4: assert property (@(posedge clk) disable iff (!rst_n) $fell(sclk) |-> hc == 8'(HI_CYC));
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |=> !rd_valid);
  p_valid_csn_r5: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> cs_n);
  p_ferr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n) !$stable(frame_err) |-> rd_valid);
endmodule

bind adc_word_reader adc_word_reader_chk #(.HI_CYC(HI_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
  .rd_valid(rd_valid), .frame_err(frame_err), .tmo_err(tmo_err)
);

// File: tb/test_adc_word_reader.sv
module test_adc_word_reader;
  localparam int HI  = 2;
  localparam int LO  = 3;
  localparam int TMO = 200;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wide = 1'b0;
  logic cs_n, sclk, rd_valid, res_sign, res_ovr, frame_err, tmo_err;
  logic [19:0] result_mag;
  logic sdi;

  logic [23:0] dev_word = '0;
  logic [7:0]  dev_pad  = 8'hFF;
  logic        dev_busy = 1'b0;
  int          idx = 0;
  int          checks = 0, fails = 0;
  bit          ended = 0;

  always #2 clk = ~clk;

  adc_word_reader #(.HI_CYC(HI), .LO_CYC(LO), .TMO_CYC(TMO)) i_adc_word_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .wide(wide), .sdi(sdi),
    .cs_n(cs_n), .sclk(sclk), .rd_valid(rd_valid), .result_mag(result_mag),
    .res_sign(res_sign), .res_ovr(res_ovr), .frame_err(frame_err), .tmo_err(tmo_err)
  );

  always @(negedge sclk or posedge cs_n)
    if (cs_n) idx <= 0; else idx <= idx + 1;

  assign sdi = cs_n ? 1'b1 : (idx == 0) ? dev_busy :
               (idx < 24) ? dev_word[23 - idx] : (idx < 32) ? dev_pad[31 - idx] : 1'b1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Runs one frame; returns cycles to rd_valid, sclk-high samples and rising edges
  task automatic run_frame(input logic [23:0] w, input logic [7:0] pad, input bit wd,
                           input int busy_cyc, input bit extra_start,
                           output int lat, output int hi_s, output int rises, output bit poll_ok);
    logic prev = 1'b0;
    dev_word = w; dev_pad = pad; dev_busy = (busy_cyc > 0);
    @(negedge clk); start = 1'b1; wide = wd;
    @(negedge clk); start = 1'b0;
    lat = 0; hi_s = 0; rises = 0; poll_ok = 1;
    while (!rd_valid && lat < 2000) begin
      @(negedge clk); lat++;
      if (lat == busy_cyc) dev_busy = 1'b0;
      if (lat < busy_cyc && (sclk || cs_n)) poll_ok = 0;
      if (extra_start && lat == 40) start = 1'b1;
      if (extra_start && lat == 41) start = 1'b0;
      if (sclk) hi_s++;
      if (sclk && !prev) rises++;
      prev = sclk;
    end
  endtask

  task automatic t_reset();
    check(cs_n === 1'b1 && sclk === 1'b0 && rd_valid === 1'b0, "R1 idle pins", {cs_n, sclk, rd_valid}, 3'b100);
    check(frame_err === 1'b0 && tmo_err === 1'b0, "R1 error flags", {frame_err, tmo_err}, 0);
  endtask

  task automatic t_basic(input logic [23:0] w, input string tag);
    int lat, hs, rs; bit pk;
    run_frame(w, 8'hFF, 1'b0, 0, 1'b0, lat, hs, rs, pk);
    check(lat == 24 * (HI + LO), {"R5 latency ", tag}, lat, 24 * (HI + LO));
    check(cs_n === 1'b1, {"R5 cs released ", tag}, cs_n, 1);
    check(rs == 24 && hs == 24 * HI, {"R4 clock count ", tag}, rs, 24);
    check(result_mag === w[19:0], {"R6 magnitude ", tag}, result_mag, w[19:0]);
    check(res_sign === w[21] && res_ovr === w[20], {"R6 flags ", tag}, {res_sign, res_ovr}, {w[21], w[20]});
    check(frame_err === w[22], {"R7 frame ", tag}, frame_err, w[22]);
    @(negedge clk);
    check(rd_valid === 1'b0, {"R5 single pulse ", tag}, rd_valid, 0);
  endtask

  task automatic t_wide(input logic [7:0] pad, input bit exp_err);
    int lat, hs, rs; bit pk;
    logic [23:0] w = {4'b0010, 20'h5A5A5};
    run_frame(w, pad, 1'b1, 0, 1'b0, lat, hs, rs, pk);
    check(rs == 32 && hs == 32 * HI, "R4 wide clock count", rs, 32);
    check(lat == 32 * (HI + LO), "R8 wide latency", lat, 32 * (HI + LO));
    check(result_mag === w[19:0], "R8 wide magnitude", result_mag, w[19:0]);
    check(frame_err === exp_err, "R8 padding check", frame_err, exp_err);
  endtask

  task automatic t_busy();
    int lat, hs, rs; bit pk;
    run_frame({4'b0011, 20'h00F0F}, 8'hFF, 1'b0, 30, 1'b0, lat, hs, rs, pk);
    check(pk, "R2 clock held low while busy", pk, 1);
    check(lat > 30 && rs == 24, "R2 read after busy clears", rs, 24);
    check(result_mag === 20'h00F0F && res_ovr === 1'b1, "R6 after polling", result_mag, 20'h00F0F);
  endtask

  task automatic t_restart();
    int lat, hs, rs; bit pk; int extra = 0;
    run_frame({4'b0010, 20'h12345}, 8'hFF, 1'b0, 0, 1'b1, lat, hs, rs, pk);
    check(lat == 24 * (HI + LO) && rs == 24, "R9 start during read ignored", lat, 24 * (HI + LO));
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (rd_valid || !cs_n) extra++;
    end
    check(extra == 0, "R9 no second frame", extra, 0);
  endtask

  task automatic t_timeout();
    int n = 0, rs = 0, v = 0;
    logic prev = 1'b0;
    dev_busy = 1'b1;
    @(negedge clk); start = 1'b1; wide = 1'b0;
    @(negedge clk); start = 1'b0;
    while (!tmo_err && n < 1000) begin
      @(negedge clk); n++;
      if (sclk && !prev) rs++;
      if (rd_valid) v++;
      prev = sclk;
    end
    check(n == TMO, "R3 timeout cycle", n, TMO);
    check(cs_n === 1'b1 && rs == 0 && v == 0, "R3 released without clocks", {cs_n, 8'(rs)}, 9'h100);
    dev_busy = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(tmo_err === 1'b0, "R3 cleared by start", tmo_err, 0);
    while (!rd_valid && n < 3000) begin @(negedge clk); n++; end
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired actual 0 expected 1");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_basic({4'b0010, 20'hA5C3E}, "positive");
    t_basic({4'b0001, 20'hFFFFF}, "negative over-range");
    t_basic({4'b0100, 20'h00001}, "dummy bit set");
    t_basic({4'b0000, 20'h80000}, "clean after error");
    t_wide(8'hFF, 1'b0);
    t_wide(8'hF7, 1'b1);
    t_busy();
    t_restart();
    t_timeout();
    summary();
  end
endmodule